// File: doc/BRIEF.md
# Single-Wire Command Transaction Controller

This block sits above a byte-level receiver/transmitter on a shared single-wire programming line. It watches the stream of received bytes for the sync byte, decodes the command byte that follows, and then steps through the data bytes of the selected transaction. It keeps a register pointer and a memory pointer. It drives a 16-bit write port and an address into a local register file. It also raises read and write requests on a two-byte port toward an external memory controller.

Read commands answer with two bytes, low byte first. The reply only starts after a turnaround of a fixed number of bit periods, which gives the remote controller time to release the line. A memory read also waits until the memory access has finished. A failed or unanswered memory access returns all ones. The byte transceiver supplies a one-cycle `bit_tick` per bit period, so all delays and timeouts are counted in bit periods and follow whatever baud rate the transceiver detected.

Top module: `sw_xact_ctrl`

## Requirements
- R1: When idle, the block only leaves the idle state on a received byte equal to 55h. Every other byte received while idle is ignored, and the register pointer on `rf_ptr` keeps its value.
- R2: The byte after the sync byte is the command. The only valid codes are 01h (set register pointer), 02h (set memory pointer), 04h (write register), 08h (write memory), 10h (read register) and 20h (read memory). Any other value returns the block to idle with no write and no memory request.
- R3: Set register pointer takes one data byte. Its low `PTR_W` bits become the pointer driven on `rf_ptr`.
- R4: Write register takes two data bytes, low byte first. The cycle after the second byte arrives, `rf_we` pulses high for exactly one cycle with all 16 bits on `rf_wdata`. The first byte alone causes no write.
- R5: Set memory pointer takes two data bytes, low byte first. Bit 0 of the stored pointer is forced to 0.
- R6: Write memory takes two data bytes, low byte first. It then raises `mem_req` with `mem_we`=1, `mem_addr` equal to the memory pointer and `mem_wdata` equal to {high, low}. The low byte belongs at the even address and the high byte at the address plus one. `mem_req` is held until `mem_done`.
- R7: Read register replies with the low byte and then the high byte of `rf_rdata` at `rf_ptr`. The first reply byte is not offered on `tx_valid` until `TURN_BITS` bit ticks have passed after the command byte.
- R8: Read memory raises `mem_req` with `mem_we`=0 at the memory pointer as soon as the command byte arrives. The reply, `mem_rdata` low byte then high byte, starts only after both the turnaround and `mem_done`.
- R9: A memory access that ends with `mem_err`, or that gets no `mem_done` within `MEM_WAIT_BITS` bit ticks, is withdrawn (`mem_req` falls). A read in that case replies FFFFh.
- R10: While waiting for a command or data byte, if `TIMEOUT_BITS` bit ticks pass with no byte, the transaction is abandoned and the block returns to idle with no write.
- R11: Bytes received during the turnaround, the reply or a memory write are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit period from the transceiver |
| rx_valid | input | 1 | A received byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Reply byte offered to the transmitter |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Transmitter accepts tx_data this cycle |
| rf_ptr | output | PTR_W | Register pointer, used for both write and read |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 16 | Register file write data |
| rf_rdata | input | 16 | Register file read data at rf_ptr |
| mem_req | output | 1 | Memory access request, held until done |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Even byte address of the access |
| mem_wdata | output | 16 | Write data, low byte at mem_addr |
| mem_done | input | 1 | Memory access finished |
| mem_err | input | 1 | Qualifies mem_done as failed |
| mem_rdata | input | 16 | Read data, valid with mem_done |

## Verification
Directed byte sequences exercise each of the six commands. Control bytes are also placed where they must not act: before a sync byte, after an unknown command, inside the turnaround window, and after a stalled data phase. A change of `rf_ptr` or a stray write then separates a correct decoder from one that mis-sequences. Memory reads are run with a slow memory, a fast memory, an erroring memory and a silent memory. This tells apart the turnaround gate, the completion gate and the all-ones fallback. The tick distance between the command byte and the first reply byte pins the turnaround length.

// File: rtl/sw_xact_pkg.sv
package sw_xact_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'h55;
    localparam int         MPTR_W    = 16;

    typedef enum logic [7:0] {
        CMD_NONE     = 8'h00,
        CMD_SET_RPTR = 8'h01,
        CMD_SET_MPTR = 8'h02,
        CMD_WR_REG   = 8'h04,
        CMD_WR_MEM   = 8'h08,
        CMD_RD_REG   = 8'h10,
        CMD_RD_MEM   = 8'h20
    } cmd_e;

    typedef enum logic [2:0] {
        ST_SYNC,
        ST_CMD,
        ST_DAT0,
        ST_DAT1,
        ST_MEMWR,
        ST_TURN,
        ST_REPLY
    } state_e;

    typedef struct packed {
        logic              we;
        logic [MPTR_W-1:0] addr;
        logic [15:0]       data;
    } mem_cmd_t;

    // single bit set within the low six positions
    function automatic logic cmd_known(input logic [7:0] b);
        return (b != 8'h00) && ((b & (b - 8'd1)) == 8'h00) && (b[7:6] == 2'b00);
    endfunction

    function automatic logic cmd_is_read(input logic [7:0] b);
        return (b == CMD_RD_REG) || (b == CMD_RD_MEM);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sw_tick_timer.sv
module sw_tick_timer #(
    parameter int MAX   = 64,
    parameter int CNT_W = $clog2(MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick && (cnt != CAP)) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r10_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        (cnt == CAP) && !clr |=> (cnt == CAP))
        else $error("timer left saturation without clear");

endmodule

// File: rtl/sw_reply_tx.sv
module sw_reply_tx (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] word,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        done
);
    logic [7:0] hi_q;
    logic       second_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            hi_q     <= '0;
            second_q <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                tx_valid <= 1'b1;
                tx_data  <= word[7:0];
                hi_q     <= word[15:8];
                second_q <= 1'b0;
            end else if (tx_valid && tx_ready) begin
                if (!second_q) begin
                    tx_data  <= hi_q;
                    second_q <= 1'b1;
                end else begin
                    tx_valid <= 1'b0;
                    done     <= 1'b1;
                end
            end
        end
    end

    a_r7_hold_byte: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data))
        else $error("reply byte changed while stalled");

endmodule

// File: rtl/sw_xact_ctrl.sv
module sw_xact_ctrl
    import sw_xact_pkg::*;
#(
    parameter int PTR_W         = 5,   // must not exceed 8
    parameter int TURN_BITS     = 8,
    parameter int TIMEOUT_BITS  = 30,
    parameter int MEM_WAIT_BITS = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic [PTR_W-1:0]  rf_ptr,
    output logic              rf_we,
    output logic [15:0]       rf_wdata,
    input  logic [15:0]       rf_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MPTR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic              mem_done,
    input  logic              mem_err,
    input  logic [15:0]       mem_rdata
);
    localparam int CNT_MAX = max3(TURN_BITS, TIMEOUT_BITS, MEM_WAIT_BITS);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] TURN_C = CNT_W'(TURN_BITS);
    localparam logic [CNT_W-1:0] IDLE_C = CNT_W'(TIMEOUT_BITS);
    localparam logic [CNT_W-1:0] MEMW_C = CNT_W'(MEM_WAIT_BITS);

    state_e            state_q, state_d;
    cmd_e              cmd_q;
    logic [7:0]        lo_q;
    logic [PTR_W-1:0]  rptr_q;
    logic [MPTR_W-1:0] mptr_q;
    logic              rf_we_q;
    logic [15:0]       rf_wdata_q;
    mem_cmd_t          mreq_q;
    logic              mreq_v_q;
    logic              got_q;
    logic [15:0]       rdata_q;

    logic [CNT_W-1:0]  tmr_cnt;
    logic              tmr_clr;
    logic              turn_ok, idle_expired, mem_expired;
    logic [15:0]       word;
    logic              reply_start, reply_done;
    logic [15:0]       reply_word;

    // one timer serves byte timeout, turnaround and memory wait
    assign tmr_clr = (state_d != state_q);

    sw_tick_timer #(.MAX(CNT_MAX), .CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .tick (bit_tick),
        .cnt  (tmr_cnt)
    );

    assign turn_ok      = (tmr_cnt >= TURN_C);
    assign idle_expired = (tmr_cnt >= IDLE_C);
    assign mem_expired  = (tmr_cnt >= MEMW_C);
    assign word         = {rx_data, lo_q};

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNC: if (rx_valid && rx_data == SYNC_BYTE) state_d = ST_CMD;
            ST_CMD: begin
                if (rx_valid) begin
                    if (!cmd_known(rx_data))     state_d = ST_SYNC;
                    else if (cmd_is_read(rx_data)) state_d = ST_TURN;
                    else                           state_d = ST_DAT0;
                end else if (idle_expired) begin
                    state_d = ST_SYNC;
                end
            end
            ST_DAT0: begin
                if (rx_valid)          state_d = (cmd_q == CMD_SET_RPTR) ? ST_SYNC : ST_DAT1;
                else if (idle_expired) state_d = ST_SYNC;
            end
            ST_DAT1: begin
                if (rx_valid)          state_d = (cmd_q == CMD_WR_MEM) ? ST_MEMWR : ST_SYNC;
                else if (idle_expired) state_d = ST_SYNC;
            end
            ST_MEMWR: if (mem_done || mem_expired) state_d = ST_SYNC;
            ST_TURN:  if (turn_ok && (cmd_q == CMD_RD_REG || got_q)) state_d = ST_REPLY;
            ST_REPLY: if (reply_done) state_d = ST_SYNC;
            default:  state_d = ST_SYNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_SYNC;
            cmd_q      <= CMD_NONE;
            lo_q       <= '0;
            rptr_q     <= '0;
            mptr_q     <= '0;
            rf_we_q    <= 1'b0;
            rf_wdata_q <= '0;
            mreq_q     <= '0;
            mreq_v_q   <= 1'b0;
            got_q      <= 1'b0;
            rdata_q    <= '0;
        end else begin
            state_q <= state_d;
            rf_we_q <= 1'b0;
            unique case (state_q)
                ST_CMD: if (rx_valid && cmd_known(rx_data)) begin
                    cmd_q <= cmd_e'(rx_data);
                    got_q <= 1'b0;
                    if (rx_data == CMD_RD_MEM) begin
                        mreq_v_q <= 1'b1;
                        mreq_q   <= '{we: 1'b0, addr: mptr_q, data: 16'h0000};
                    end
                end
                ST_DAT0: if (rx_valid) begin
                    lo_q <= rx_data;
                    if (cmd_q == CMD_SET_RPTR) rptr_q <= rx_data[PTR_W-1:0];
                end
                ST_DAT1: if (rx_valid) begin
                    case (cmd_q)
                        CMD_SET_MPTR: mptr_q <= {word[15:1], 1'b0};
                        CMD_WR_REG: begin
                            rf_we_q    <= 1'b1;
                            rf_wdata_q <= word;
                        end
                        CMD_WR_MEM: begin
                            mreq_v_q <= 1'b1;
                            mreq_q   <= '{we: 1'b1, addr: mptr_q, data: word};
                        end
                        default: ;
                    endcase
                end
                ST_MEMWR: if (mem_done || mem_expired) mreq_v_q <= 1'b0;
                ST_TURN: if (mreq_v_q) begin
                    if (mem_done) begin
                        mreq_v_q <= 1'b0;
                        got_q    <= 1'b1;
                        rdata_q  <= mem_err ? 16'hFFFF : mem_rdata;
                    end else if (mem_expired) begin
                        mreq_v_q <= 1'b0;
                        got_q    <= 1'b1;
                        rdata_q  <= 16'hFFFF;
                    end
                end
                default: ;
            endcase
        end
    end

    assign reply_start = (state_q == ST_TURN) && (state_d == ST_REPLY);
    assign reply_word  = (cmd_q == CMD_RD_REG) ? rf_rdata : rdata_q;

    sw_reply_tx u_reply (
        .clk      (clk),
        .rst      (rst),
        .start    (reply_start),
        .word     (reply_word),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .done     (reply_done)
    );

    assign rf_ptr    = rptr_q;
    assign rf_we     = rf_we_q;
    assign rf_wdata  = rf_wdata_q;
    assign mem_req   = mreq_v_q;
    assign mem_we    = mreq_q.we;
    assign mem_addr  = mreq_q.addr;
    assign mem_wdata = mreq_q.data;

    a_r4_we_single: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we)
        else $error("register write strobe longer than one cycle");

    a_r5_addr_even: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !mem_addr[0])
        else $error("memory request at odd address");

    a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_done && !mem_expired |=> mem_req && $stable(mem_addr))
        else $error("memory request dropped before completion");

    a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> $past(turn_ok))
        else $error("reply started before turnaround elapsed");

    a_r11_no_req_in_reply: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !mem_req)
        else $error("memory request still open during reply");

endmodule

// File: tb/tb_sw_xact_ctrl.sv
module tb_sw_xact_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        bit_tick;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready;
    logic [4:0]  rf_ptr;
    logic        rf_we;
    logic [15:0] rf_wdata;
    logic [15:0] rf_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_done, mem_err;
    logic [15:0] mem_rdata;

    always #10 clk = ~clk;

    sw_xact_ctrl dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rf_ptr(rf_ptr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_done(mem_done), .mem_err(mem_err), .mem_rdata(mem_rdata)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tick_total = 0;
    int mark_tick, mark_cyc;

    // bit period of four clocks
    always @(negedge clk) begin
        cyc = cyc + 1;
        bit_tick = (cyc % 4 == 0);
        if (cyc % 4 == 0) tick_total = tick_total + 1;
    end

    // register file model
    logic [15:0] rf [32];
    int wr_count = 0;
    assign rf_rdata = rf[rf_ptr];
    always @(negedge clk) begin
        if (!rst && rf_we) begin
            rf[rf_ptr] = rf_wdata;
            wr_count = wr_count + 1;
        end
    end

    // memory model: 0 answers, 1 errors, 2 never answers
    logic [15:0] mem [128];
    int mem_mode = 0;
    int mem_delay = 20;
    bit mbusy = 0;
    int mcnt = 0;
    int mreq_count = 0;
    int done_cyc = 0;
    logic [15:0] last_addr;
    logic        last_we;
    always @(negedge clk) begin
        mem_done = 1'b0;
        mem_err  = 1'b0;
        if (!mem_req) begin
            mbusy = 0;
        end else if (!mbusy) begin
            mbusy = 1;
            mcnt = mem_delay;
            mreq_count = mreq_count + 1;
            last_addr = mem_addr;
            last_we = mem_we;
            if (mem_we) mem[mem_addr[7:1]] = mem_wdata;
        end else if (mcnt > 0) begin
            mcnt = mcnt - 1;
        end else if (mem_mode != 2) begin
            mem_done  = 1'b1;
            mem_err   = (mem_mode == 1);
            mem_rdata = mem[last_addr[7:1]];
            done_cyc  = cyc;
        end
    end

    // reply capture
    logic [7:0] txq[$];
    int first_tx_cyc, first_tx_ticks;
    always @(negedge clk) begin
        #1;
        if (tx_valid && tx_ready) begin
            if (txq.size() == 0) begin
                first_tx_cyc = cyc;
                first_tx_ticks = tick_total;
            end
            txq.push_back(tx_data);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input int gap);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        #1;
        mark_tick = tick_total;
        mark_cyc  = cyc;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic wait_reply();
        for (int i = 0; i < 800 && txq.size() < 2; i++) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!tx_valid && !rf_we && !mem_req, "R1 reset idle outputs", {tx_valid, rf_we, mem_req}, 0);
        chk(rf_ptr == 5'd0, "R1 reset pointer", rf_ptr, 0);
    endtask

    task automatic t_no_sync();
        send_byte(8'h01, 40);
        send_byte(8'h1F, 40);
        chk(rf_ptr == 5'd0, "R1 bytes without sync ignored", rf_ptr, 0);
    endtask

    task automatic t_set_rptr();
        send_byte(8'h55, 40); send_byte(8'h01, 40); send_byte(8'hE5, 40);
        chk(rf_ptr == 5'd5, "R3 pointer from low bits", rf_ptr, 5);
    endtask

    task automatic t_write_reg();
        int w0 = wr_count;
        send_byte(8'h55, 40); send_byte(8'h04, 40); send_byte(8'h34, 40);
        chk(wr_count == w0, "R4 no write after first byte", wr_count, w0);
        send_byte(8'h12, 40);
        chk(wr_count == w0 + 1, "R4 exactly one write", wr_count, w0 + 1);
        chk(rf[5] == 16'h1234, "R4 16-bit word low byte first", rf[5], 16'h1234);
    endtask

    task automatic t_read_reg();
        int mt;
        rf[9] = 16'hA55A;
        send_byte(8'h55, 40); send_byte(8'h01, 40); send_byte(8'h09, 40);
        txq.delete();
        send_byte(8'h55, 40); send_byte(8'h10, 0);
        mt = mark_tick;
        wait_reply();
        chk(txq.size() == 2, "R7 two reply bytes", txq.size(), 2);
        if (txq.size() == 2)
            chk(txq[0] == 8'h5A && txq[1] == 8'hA5, "R7 low byte then high", {txq[0], txq[1]}, 16'h5AA5);
        chk(first_tx_ticks - mt >= 8 && first_tx_ticks - mt <= 9, "R7 turnaround eight bit periods",
            first_tx_ticks - mt, 8);
    endtask

    task automatic t_write_mem();
        int m0;
        send_byte(8'h55, 40); send_byte(8'h02, 40); send_byte(8'h37, 40); send_byte(8'h12, 40);
        m0 = mreq_count;
        mem_mode = 0; mem_delay = 20;
        send_byte(8'h55, 40); send_byte(8'h08, 40); send_byte(8'hCD, 40); send_byte(8'hAB, 60);
        chk(mreq_count == m0 + 1, "R6 one memory write request", mreq_count, m0 + 1);
        chk(last_addr == 16'h1236, "R5 memory pointer bit0 cleared", last_addr, 16'h1236);
        chk(last_we == 1'b1, "R6 write request flag", last_we, 1);
        chk(mem[7'h1B] == 16'hABCD, "R6 write data low byte first", mem[7'h1B], 16'hABCD);
        chk(!mem_req, "R6 request released after done", mem_req, 0);
    endtask

    task automatic t_read_mem_slow();
        mem_mode = 0; mem_delay = 60;
        txq.delete();
        send_byte(8'h55, 40); send_byte(8'h20, 0);
        wait_reply();
        chk(last_we == 1'b0 && last_addr == 16'h1236, "R8 read request at pointer", {last_we, last_addr}, 16'h1236);
        if (txq.size() == 2)
            chk(txq[0] == 8'hCD && txq[1] == 8'hAB, "R8 memory reply bytes", {txq[0], txq[1]}, 16'hCDAB);
        else chk(0, "R8 memory reply count", txq.size(), 2);
        chk(first_tx_cyc > done_cyc, "R8 reply after memory done", first_tx_cyc, done_cyc + 1);
    endtask

    task automatic t_read_mem_fast();
        int mt;
        mem_mode = 0; mem_delay = 2;
        txq.delete();
        send_byte(8'h55, 40); send_byte(8'h20, 0);
        mt = mark_tick;
        wait_reply();
        chk(txq.size() == 2 && first_tx_ticks - mt >= 8, "R8 fast memory still waits turnaround",
            first_tx_ticks - mt, 8);
    endtask

    task automatic t_mem_fail(input int mode);
        mem_mode = mode; mem_delay = 5;
        txq.delete();
        send_byte(8'h55, 40); send_byte(8'h20, 0);
        wait_reply();
        if (txq.size() == 2)
            chk(txq[0] == 8'hFF && txq[1] == 8'hFF, "R9 failed memory read all ones", {txq[0], txq[1]}, 16'hFFFF);
        else chk(0, "R9 failed memory reply count", txq.size(), 2);
        chk(!mem_req, "R9 request withdrawn", mem_req, 0);
        mem_mode = 0;
    endtask

    task automatic t_bad_cmd();
        int w0 = wr_count;
        int m0 = mreq_count;
        send_byte(8'h55, 40); send_byte(8'h03, 40);
        send_byte(8'h55, 40); send_byte(8'h01, 40); send_byte(8'h07, 40);
        chk(rf_ptr == 5'd7, "R2 code 03h rejected", rf_ptr, 7);
        send_byte(8'h55, 40); send_byte(8'h40, 40);
        send_byte(8'h55, 40); send_byte(8'h01, 40); send_byte(8'h08, 40);
        chk(rf_ptr == 5'd8, "R2 code 40h rejected", rf_ptr, 8);
        chk(wr_count == w0 && mreq_count == m0, "R2 no side effect", wr_count, w0);
    endtask

    task automatic t_timeout();
        int w0 = wr_count;
        send_byte(8'h55, 40); send_byte(8'h04, 40); send_byte(8'h11, 200);
        send_byte(8'h55, 40); send_byte(8'h01, 40); send_byte(8'h0A, 40);
        chk(rf_ptr == 5'd10, "R10 stalled transaction abandoned", rf_ptr, 10);
        chk(wr_count == w0, "R10 no write after timeout", wr_count, w0);
    endtask

    task automatic t_ignore_in_turn();
        rf[10] = 16'hBEEF;
        txq.delete();
        send_byte(8'h55, 40); send_byte(8'h10, 6);
        send_byte(8'h55, 6); send_byte(8'h01, 6); send_byte(8'h1E, 0);
        wait_reply();
        chk(rf_ptr == 5'd10, "R11 bytes during turnaround ignored", rf_ptr, 10);
        if (txq.size() == 2)
            chk(txq[0] == 8'hEF && txq[1] == 8'hBE, "R11 reply intact", {txq[0], txq[1]}, 16'hBEEF);
        else chk(0, "R11 reply count", txq.size(), 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = 16'h0000;
        for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
        rst = 1'b1; rx_valid = 1'b0; rx_data = 8'h00; tx_ready = 1'b1;
        mem_done = 1'b0; mem_err = 1'b0; mem_rdata = 16'h0000; bit_tick = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_no_sync();
        t_set_rptr();
        t_write_reg();
        t_read_reg();
        t_write_mem();
        t_read_mem_slow();
        t_read_mem_fast();
        t_mem_fail(1);
        t_mem_fail(2);
        t_bad_cmd();
        t_timeout();
        t_ignore_in_turn();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule